// File: doc/BRIEF.md
# Coin-Summing Vend Controller

A small custom processor that adds up coin values until they reach a product price. Each coin arrives as a one-cycle strobe together with the coin's value. Once the running total is equal to or above the price, the block raises a vend strobe for one cycle and then starts again from zero. Change, refunds, coin validation and overflow reporting are not part of this block.

Inside, a four-state controller steers a datapath made of a total register, an adder and an unsigned less-than comparator. The controller's only inputs are the coin strobe and the comparator's "below price" flag. Its only outputs are the vend strobe, a load enable and a clear enable for the total. All outputs depend only on the current state.

The states are:
- IDLE_CLR: clears the total, then goes to WAIT.
- WAIT: a coin strobe moves it to ADD. With no strobe, it stays in WAIT while the total is below the price, and otherwise moves to VEND.
- ADD: loads total + coin value, then goes back to WAIT.
- VEND: raises the vend strobe, then goes to IDLE_CLR.

Top module: `coin_vend`

## Requirements
- R1: A synchronous active-high reset puts the controller in IDLE_CLR with the total at zero and `vend_out` low.
- R2: IDLE_CLR sets the total to zero and, after one cycle, always moves to WAIT.
- R3: In WAIT, a high `coin_pulse` moves the controller to ADD. This takes priority over the price check, even when the total already meets the price.
- R4: In WAIT with `coin_pulse` low, the controller stays in WAIT while the total is below `price`, and the total does not change. Otherwise it moves to VEND.
- R5: In ADD, the total becomes total + `coin_val`, using the `coin_val` present during the ADD cycle. The controller then returns to WAIT.
- R6: In VEND, `vend_out` is high for exactly one cycle. The controller then goes to IDLE_CLR, so the next purchase starts from a total of zero.
- R7: The total is a WIDTH-bit register (default 8) that wraps modulo 2^WIDTH without any indication.
- R8: The comparison of total against `price` is unsigned. For example, a total of 128 meets a price of 128, and a total of 127 does not.
- R9: If `coin_pulse` is held high, the coin value is added once more on every visit to ADD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_pulse | input | 1 | One-cycle strobe per deposited coin |
| coin_val | input | WIDTH | Value of the deposited coin; must stay valid through the ADD cycle |
| price | input | WIDTH | Product price, unsigned |
| vend_out | output | 1 | One-cycle dispense strobe |

## Verification
The accumulation is tested with several coin patterns:
- A single exact coin, which shows that a dispense happens on equality.
- Several small coins, which shows that partial totals do not dispense early.
- An overshoot, which confirms the at-or-above rule.
- A coin sequence whose sum passes 255, which shows that the total wraps instead of saturating or widening.
- A price of 128 with totals of 127 and then 128, which separates an unsigned compare from a signed one.

A zero price with no coins shows the free-running WAIT/VEND/IDLE_CLR loop. A coin strobe held high while the total already meets the price shows that the coin strobe wins and adds again. A reset in the middle of a purchase and a purchase right after a dispense both show that the old total is dropped.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_CLR = 2'd0,
        ST_WAIT     = 2'd1,
        ST_ADD      = 2'd2,
        ST_VEND     = 2'd3
    } vend_state_e;

    typedef struct packed {
        logic vend;
        logic tot_load;
        logic tot_clear;
    } vend_ctrl_t;

endpackage

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       coin_pulse,
    input  logic       below_price,
    output vend_ctrl_t ctrl
);

    vend_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_CLR: state_d = ST_WAIT;
            ST_WAIT: begin
                if (coin_pulse)
                    state_d = ST_ADD;      // coin strobe wins
                else if (!below_price)
                    state_d = ST_VEND;
                else
                    state_d = ST_WAIT;
            end
            ST_ADD:  state_d = ST_WAIT;
            ST_VEND: state_d = ST_IDLE_CLR;
            default: state_d = ST_IDLE_CLR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE_CLR;
        else
            state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_IDLE_CLR: ctrl.tot_clear = 1'b1;
            ST_WAIT:     ctrl = '0;
            ST_ADD:      ctrl.tot_load  = 1'b1;
            ST_VEND:     ctrl.vend      = 1'b1;
            default:     ctrl = '0;
        endcase
    end

endmodule

// File: rtl/coin_vend_accum.sv
module coin_vend_accum #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tot_clear,
    input  logic             tot_load,
    input  logic [WIDTH-1:0] coin_val,
    output logic [WIDTH-1:0] total
);

    logic [WIDTH-1:0] sum;

    // Wrapping adder: the carry out is dropped on purpose
    assign sum = total + coin_val;

    always_ff @(posedge clk) begin
        if (rst || tot_clear)
            total <= '0;
        else if (tot_load)
            total <= sum;
    end

endmodule

// File: rtl/coin_vend_cmp.sv
module coin_vend_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] total,
    input  logic [WIDTH-1:0] price,
    output logic             below_price
);

    // Unsigned magnitude compare
    assign below_price = (total < price);

endmodule

// File: rtl/coin_vend.sv
module coin_vend
    import coin_vend_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             coin_pulse,
    input  logic [WIDTH-1:0] coin_val,
    input  logic [WIDTH-1:0] price,
    output logic             vend_out
);

    vend_ctrl_t       ctrl;
    logic             below_price;
    logic [WIDTH-1:0] total;

    coin_vend_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .coin_pulse  (coin_pulse),
        .below_price (below_price),
        .ctrl        (ctrl)
    );

    coin_vend_accum #(.WIDTH(WIDTH)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .tot_clear (ctrl.tot_clear),
        .tot_load  (ctrl.tot_load),
        .coin_val  (coin_val),
        .total     (total)
    );

    coin_vend_cmp #(.WIDTH(WIDTH)) u_cmp (
        .total       (total),
        .price       (price),
        .below_price (below_price)
    );

    assign vend_out = ctrl.vend;

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             coin_pulse,
    input logic [WIDTH-1:0] coin_val,
    input logic             vend_out,
    input logic             tot_load,
    input logic             tot_clear,
    input logic             below_price,
    input logic [WIDTH-1:0] total
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (total == '0) && !vend_out); // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        tot_clear |=> (total == '0)); // R2

    AST_VEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        vend_out |-> $past(!coin_pulse && !below_price)); // R3

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tot_load && !tot_clear) |=> $stable(total)); // R4

    AST_LOAD_SUM: assert property (@(posedge clk) disable iff (rst)
        tot_load |=> (total == WIDTH'($past(total) + $past(coin_val)))); // R5

    AST_VEND_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vend_out |=> (!vend_out && tot_clear)); // R6

    AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vend_out, tot_load, tot_clear})); // R6

endmodule

bind coin_vend coin_vend_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .coin_pulse  (coin_pulse),
    .coin_val    (coin_val),
    .vend_out    (vend_out),
    .tot_load    (ctrl.tot_load),
    .tot_clear   (ctrl.tot_clear),
    .below_price (below_price),
    .total       (total)
);

// File: tb/coin_vend_tb.sv
module coin_vend_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         coin_pulse = 1'b0;
    logic [W-1:0] coin_val = '0;
    logic [W-1:0] price = '0;
    logic         vend_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    coin_vend #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .coin_pulse (coin_pulse),
        .coin_val   (coin_val),
        .price      (price),
        .vend_out   (vend_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic expv);
        n_checks++;
        if (vend_out !== expv) begin
            n_fails++;
            $display("FAIL %s: vend_out=%b expected=%b at %0t", req, vend_out, expv, $time);
        end
    endtask

    // Leaves the controller in WAIT
    task automatic do_reset(logic [W-1:0] p);
        price = p;
        rst = 1'b1;
        tick();
        tick();
        chk("R1", 1'b0);
        rst = 1'b0;
        tick();
        chk("R2", 1'b0);
    endtask

    // Starts in WAIT; returns in WAIT with the total updated
    task automatic drop_coin(logic [W-1:0] v);
        coin_pulse = 1'b1;
        coin_val = v;
        tick();
        coin_pulse = 1'b0;
        tick();
        coin_val = '0;
    endtask

    // From WAIT after a dispense check: VEND -> IDLE_CLR -> WAIT
    task automatic after_vend();
        tick();
        chk("R6", 1'b0);
        tick();
    endtask

    task automatic t_reset();
        price = 8'd25;
        rst = 1'b1;
        tick();
        chk("R1", 1'b0);
        do_reset(8'd25);
        tick();
        chk("R4", 1'b0);
    endtask

    task automatic t_exact();
        do_reset(8'd25);
        drop_coin(8'd25);
        tick();
        chk("R4", 1'b1);
        after_vend();
    endtask

    task automatic t_several();
        do_reset(8'd25);
        drop_coin(8'd10);
        tick();
        chk("R4", 1'b0);
        drop_coin(8'd10);
        tick();
        chk("R5", 1'b0);
        drop_coin(8'd5);
        tick();
        chk("R5", 1'b1);
        after_vend();
        // The total restarted from zero after the vend
        drop_coin(8'd10);
        tick();
        chk("R6", 1'b0);
        drop_coin(8'd15);
        tick();
        chk("R6", 1'b1);
        after_vend();
    endtask

    task automatic t_overshoot();
        do_reset(8'd25);
        drop_coin(8'd20);
        tick();
        chk("R4", 1'b0);
        drop_coin(8'd10);
        tick();
        chk("R4", 1'b1);
        after_vend();
    endtask

    task automatic t_wrap();
        do_reset(8'd200);
        drop_coin(8'd150);
        tick();
        chk("R7", 1'b0);
        drop_coin(8'd150);
        tick();
        chk("R7", 1'b0);   // 300 mod 256 = 44
        drop_coin(8'd160);
        tick();
        chk("R7", 1'b1);   // 204
        after_vend();
    endtask

    task automatic t_unsigned();
        do_reset(8'd128);
        drop_coin(8'd127);
        tick();
        chk("R8", 1'b0);
        drop_coin(8'd1);
        tick();
        chk("R8", 1'b1);
        after_vend();
    endtask

    task automatic t_zero_price();
        do_reset(8'd0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4", 1'b1);
            tick();
            chk("R2", 1'b0);
            tick();
            chk("R2", 1'b0);
        end
        price = 8'd50;
        tick();
        chk("R4", 1'b0);
    endtask

    task automatic t_priority();
        do_reset(8'd5);
        coin_pulse = 1'b1;
        coin_val = 8'd5;
        tick();            // ADD
        tick();            // WAIT, total 5
        chk("R9", 1'b0);
        tick();            // coin still high: ADD, not VEND
        chk("R3", 1'b0);
        coin_pulse = 1'b0;
        tick();            // WAIT, total 10
        chk("R9", 1'b0);
        coin_val = '0;
        tick();
        chk("R3", 1'b1);
        after_vend();
    endtask

    task automatic t_mid_reset();
        do_reset(8'd25);
        drop_coin(8'd10);
        tick();
        chk("R4", 1'b0);
        do_reset(8'd25);
        drop_coin(8'd20);
        tick();
        chk("R1", 1'b0);   // 20, not 30
        drop_coin(8'd5);
        tick();
        chk("R1", 1'b1);
        after_vend();
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_exact();
        t_several();
        t_overshoot();
        t_wrap();
        t_unsigned();
        t_zero_price();
        t_priority();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule